// File: doc/BRIEF.md
# Secondary Core Hotplug Request Generator

This block decides when a power manager should ask for the second CPU core to be switched on or off. On each sample strobe it compares a CPU load gauge, given as a frequency, against two hysteresis thresholds. The lower threshold is the switch-off point and the upper threshold is the switch-on point. Each threshold comes from a fraction of the maximum CPU frequency, unless a fixed nonzero value is supplied for it.

A switch is requested only after the load has stayed on one side for a number of consecutive samples. The block also remembers the last request it issued, and it issues a request only when that request differs from the previous one and matches the actual reset state of the core. When it issues a switch-on request, it also forces its frequency output to the maximum so that the caller can raise the clock at once. At all other times the frequency output passes the load gauge through unchanged.

Top module: `core1_hotplug_req`

## Requirements
- R1: With both fixed inputs at zero, the low threshold is floor(max/3) and the high threshold is floor(2*max/3). A load strictly below the low threshold counts as low, a load strictly above the high threshold counts as high, and a load equal to either threshold counts as neither.
- R2: A nonzero `fix_lo_khz` replaces the derived low threshold, and a nonzero `fix_hi_khz` replaces the derived high threshold.
- R3: A low sample clears the high-side counter. It issues nothing during the first OFF_HOLD consecutive low-side samples, which only advance the low-side counter.
- R4: On a low sample taken after the low-side counter is full, an off request is issued only if the last request was on and `core_in_reset` is 0.
- R5: A high sample clears the low-side counter. It issues nothing during the first ON_HOLD high-side samples, which only advance the high-side counter.
- R6: On a high sample taken after the high-side counter is full, an on request is issued only if the last request was off and `core_in_reset` is 1. During that cycle `freq_khz` equals `max_khz`.
- R7: After reset, the last request is taken as on, so the first request that can be issued is an off request.
- R8: `req_code` bit 3 is the on flag, bit 2 is the off flag, and bits 1:0 hold the core index, which is 1. On is 4'b1001, off is 4'b0101, and no request is 4'b0000.
- R9: A sample between the thresholds leaves both counters unchanged and issues no request.
- R10: `req_code` is nonzero only in a cycle with `sample` high. In every cycle without an on request, `freq_khz` equals `load_khz`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample | input | 1 | Single-cycle evaluation strobe |
| load_khz | input | FW | CPU load gauge expressed as a frequency |
| max_khz | input | FW | Maximum CPU frequency |
| fix_lo_khz | input | FW | Fixed low threshold; zero selects max/3 |
| fix_hi_khz | input | FW | Fixed high threshold; zero selects 2*max/3 |
| core_in_reset | input | 1 | High while the secondary core is held in reset |
| req_code | output | 4 | Request code, valid in the strobe cycle |
| freq_khz | output | FW | Load passed through, or max on an on request |

## Verification
The bench uses FW=16, OFF_HOLD=3 and ON_HOLD=2. These short hold counts let a few samples fill each counter, so that clearing a counter, interleaving samples between the thresholds and blocking a request on the core state each show up as a request issued at a different sample. It mostly uses a maximum of 3000, which gives exact thresholds of 1000 and 2000 for the boundary loads. It then uses a maximum of 100, where flooring changes the upper threshold to 66, and also sets fixed thresholds that take the place of the derived ones.

// File: rtl/core1_hotplug_req.sv
module core1_hotplug_req #(
  parameter int FW       = 16,
  parameter int CW       = 4,
  parameter int OFF_HOLD = 3,
  parameter int ON_HOLD  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic [FW-1:0] load_khz,
  input  logic [FW-1:0] max_khz,
  input  logic [FW-1:0] fix_lo_khz,
  input  logic [FW-1:0] fix_hi_khz,
  input  logic          core_in_reset,
  output logic [3:0]    req_code,
  output logic [FW-1:0] freq_khz
);
  localparam logic [3:0]    REQ_ON  = 4'b1001;
  localparam logic [3:0]    REQ_OFF = 4'b0101;
  localparam logic [CW-1:0] OFF_LIM = CW'(OFF_HOLD);
  localparam logic [CW-1:0] ON_LIM  = CW'(ON_HOLD);

  logic [FW-1:0] lo_thr, hi_thr;
  logic [CW-1:0] off_cnt, on_cnt;
  logic          last_on;
  logic          below, above, off_go, on_go;

  assign lo_thr = (fix_lo_khz != '0) ? fix_lo_khz : FW'(max_khz / 3);
  assign hi_thr = (fix_hi_khz != '0) ? fix_hi_khz : FW'({max_khz, 1'b0} / 3);

  assign below  = load_khz < lo_thr;
  assign above  = !below && (load_khz > hi_thr);
  assign off_go = sample && below && (off_cnt >= OFF_LIM) && last_on && !core_in_reset;
  assign on_go  = sample && above && (on_cnt >= ON_LIM) && !last_on && core_in_reset;

  assign req_code = on_go ? REQ_ON : (off_go ? REQ_OFF : 4'b0000);
  assign freq_khz = on_go ? max_khz : load_khz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_cnt <= '0;
      on_cnt  <= '0;
      last_on <= 1'b1;
    end else if (sample) begin
      if (below) begin
        on_cnt <= '0;
        if (off_cnt < OFF_LIM) off_cnt <= off_cnt + 1'b1;
      end else if (above) begin
        off_cnt <= '0;
        if (on_cnt < ON_LIM) on_cnt <= on_cnt + 1'b1;
      end
      if (off_go) last_on <= 1'b0;
      if (on_go)  last_on <= 1'b1;
    end
  end
endmodule

// File: rtl/core1_hotplug_req_chk.sv
module core1_hotplug_req_chk #(
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample,
  input logic [FW-1:0] load_khz,
  input logic [FW-1:0] max_khz,
  input logic          core_in_reset,
  input logic [3:0]    req_code,
  input logic [FW-1:0] freq_khz
);
  logic seen_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_on <= 1'b1;
    else if (req_code == 4'b1001) seen_on <= 1'b1;
    else if (req_code == 4'b0101) seen_on <= 1'b0;
  end

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    req_code == 4'b0000 || req_code == 4'b1001 || req_code == 4'b0101); // R8
  AST_REQ_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    req_code != 4'b0000 |-> sample); // R10
  AST_PASS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    req_code != 4'b1001 |-> freq_khz == load_khz); // R10
  AST_ON_FORCES_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    req_code == 4'b1001 |-> freq_khz == max_khz); // R6
  AST_ON_NEEDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    req_code == 4'b1001 |-> core_in_reset && !seen_on); // R6
  AST_OFF_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    req_code == 4'b0101 |-> !core_in_reset && seen_on); // R4
endmodule

bind core1_hotplug_req core1_hotplug_req_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample(sample), .load_khz(load_khz),
  .max_khz(max_khz), .core_in_reset(core_in_reset),
  .req_code(req_code), .freq_khz(freq_khz)
);

// File: tb/core1_hotplug_req_tb.sv
`timescale 1ns/1ps
module core1_hotplug_req_tb;
  localparam int FW = 16;
  localparam logic [3:0] NONE = 4'b0000, ON = 4'b1001, OFF = 4'b0101;

  logic clk = 1'b0, rst_n = 1'b0, sample = 1'b0, core_in_reset = 1'b0;
  logic [FW-1:0] load_khz = '0, max_khz = 16'd3000, fix_lo_khz = '0, fix_hi_khz = '0;
  logic [3:0] req_code;
  logic [FW-1:0] freq_khz;
  int n_chk = 0, n_bad = 0;
  logic [3:0]    q_req[$];
  logic [FW-1:0] q_frq[$];
  string         q_tag[$];
  logic run = 1'b0;

  always #2 clk = ~clk;

  core1_hotplug_req #(.FW(FW), .CW(3), .OFF_HOLD(3), .ON_HOLD(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample(sample), .load_khz(load_khz),
    .max_khz(max_khz), .fix_lo_khz(fix_lo_khz), .fix_hi_khz(fix_hi_khz),
    .core_in_reset(core_in_reset), .req_code(req_code), .freq_khz(freq_khz));

  task automatic cmp(string tag, logic [3:0] er, logic [FW-1:0] ef);
    n_chk++;
    if (req_code !== er || freq_khz !== ef) begin
      n_bad++;
      $display("FAIL %s: req=%b freq=%0d expected req=%b freq=%0d",
               tag, req_code, freq_khz, er, ef);
    end
  endtask

  always begin
    @(negedge clk); #1;
    if (run) begin
      if (sample) begin
        if (q_req.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R10: strobe with empty scoreboard");
        end else begin
          logic [3:0] er; logic [FW-1:0] ef; string t;
          er = q_req.pop_front(); ef = q_frq.pop_front(); t = q_tag.pop_front();
          cmp(t, er, ef);
        end
      end else cmp("R10 idle", NONE, load_khz);
    end
  end

  task automatic step(logic [FW-1:0] ld, logic inres, logic [3:0] er,
                      logic [FW-1:0] ef, string tag);
    @(negedge clk);
    load_khz = ld; core_in_reset = inres; sample = 1'b1;
    q_req.push_back(er); q_frq.push_back(ef); q_tag.push_back(tag);
    @(negedge clk);
    sample = 1'b0;
  endtask

  initial begin
    #40000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    load_khz = 16'd777;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    cmp("R7 reset state", NONE, 16'd777);
    run = 1'b1;
    // R7: last request is on after reset, so high load never requests on
    step(2500, 1, NONE, 2500, "R5 hold 1");
    step(2500, 1, NONE, 2500, "R5 hold 2");
    step(2500, 1, NONE, 2500, "R7 no on after reset");
    // R3/R4
    for (int i = 0; i < 3; i++) step(500, 1, NONE, 500, "R3 off hold");
    step(500, 1, NONE, 500, "R4 blocked core in reset");
    step(500, 0, OFF, 500, "R4 off issued R8");
    step(500, 0, NONE, 500, "R4 no repeat off");
    step(1500, 0, NONE, 1500, "R9 mid");
    // R5/R6
    step(2500, 0, NONE, 2500, "R5 hold 1");
    step(2500, 0, NONE, 2500, "R5 hold 2");
    step(2500, 0, NONE, 2500, "R6 blocked core running");
    step(2500, 1, ON, 3000, "R6 on issued freq max R8");
    // R9: mid sample keeps off counter
    step(500, 0, NONE, 500, "R3 off 1");
    step(500, 0, NONE, 500, "R3 off 2");
    step(1500, 0, NONE, 1500, "R9 mid keeps count");
    step(500, 0, NONE, 500, "R3 off 3");
    step(500, 0, OFF, 500, "R9 off after interleave");
    // R3: low sample clears high-side count
    step(2500, 1, NONE, 2500, "R5 hold 1");
    step(500, 1, NONE, 500, "R3 clears on count");
    step(2500, 1, NONE, 2500, "R5 hold 1 again");
    step(2500, 1, NONE, 2500, "R5 hold 2 again");
    step(2500, 1, ON, 3000, "R6 on after restart");
    // R1 boundaries at 1000/2000
    for (int i = 0; i < 5; i++) step(1000, 0, NONE, 1000, "R1 equal low is mid");
    for (int i = 0; i < 3; i++) step(999, 0, NONE, 999, "R1 999 below hold");
    step(999, 0, OFF, 999, "R1 999 off");
    for (int i = 0; i < 4; i++) step(2000, 1, NONE, 2000, "R1 equal high is mid");
    step(2001, 1, NONE, 2001, "R1 above hold 1");
    step(2001, 1, NONE, 2001, "R1 above hold 2");
    step(2001, 1, ON, 3000, "R1 2001 on");
    // R2 fixed thresholds
    fix_lo_khz = 16'd2800; fix_hi_khz = 16'd2900;
    for (int i = 0; i < 3; i++) step(2700, 0, NONE, 2700, "R2 fixed low hold");
    step(2700, 0, OFF, 2700, "R2 fixed low off");
    step(2850, 1, NONE, 2850, "R2 fixed mid");
    step(2950, 1, NONE, 2950, "R2 fixed high 1");
    step(2950, 1, NONE, 2950, "R2 fixed high 2");
    step(2950, 1, ON, 3000, "R2 fixed high on");
    // R1 flooring with max 100: lo 33, hi 66
    fix_lo_khz = '0; fix_hi_khz = '0; max_khz = 16'd100;
    for (int i = 0; i < 3; i++) step(32, 0, NONE, 32, "R1 odd low hold");
    step(33, 0, NONE, 33, "R1 33 is mid");
    step(32, 0, OFF, 32, "R1 odd low off");
    for (int i = 0; i < 3; i++) step(66, 1, NONE, 66, "R1 66 is mid");
    step(67, 1, NONE, 67, "R1 67 hold 1");
    step(67, 1, NONE, 67, "R1 67 hold 2");
    step(67, 1, ON, 100, "R1 odd on max 100");
    repeat (2) @(negedge clk);
    if (q_req.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R10: %0d results missing, expected 0", q_req.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule